// File: doc/BRIEF.md
# Consecutive Fault Qualification Queue

This block sits between a temperature comparator and the alarm pins of a sensor. Every time a new sample is converted, a strobe arrives together with three compare results: the reading is below the low limit, above the high limit, or above the critical limit. The block decides which of these results count as real faults. It drives a status flag for each condition, an interrupt output for the low and high window, and a critical alarm output.

When queueing is enabled, a condition has to be present on an unbroken run of `DEPTH` strobed samples (four by default) before its flag rises. A single clean sample ends the run and clears the flag. When queueing is disabled, one faulting sample is enough.

The interrupt output has two modes. In comparator mode it mirrors the low and high flags. In interrupt mode it latches on a new low or high event and is released by a register read on the bus. Shutdown clears the whole block and holds it idle.

Top module: `fault_qualifier`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all run counters, all three flags, `int_o` and `crit_o`.
- R2: With queueing enabled, a flag rises on the strobed sample that completes a run of `DEPTH` consecutive faulting samples for its condition, and no earlier.
- R3: A strobed sample on which a condition is absent restarts that condition's run from zero and clears its flag on the same sample.
- R4: With queueing disabled, a single faulting strobed sample sets the condition's flag.
- R5: Compare inputs are used only in cycles where `smp_vld` is high. Without a strobe, no counter or flag changes.
- R6: In comparator mode (`int_mode` = 0), `int_o` equals `flag_low OR flag_high`, and `reg_rd` has no effect on it.
- R7: In interrupt mode (`int_mode` = 1), `int_o` sets on the sample where `flag_low` or `flag_high` changes from 0 to 1, and holds until a `reg_rd` pulse clears it. If a new event and a read fall in the same cycle, the event wins.
- R8: `crit_o` follows `flag_crit`. It is not affected by `reg_rd` and does not drive `int_o`.
- R9: While `shutdown` is high, all counters and flags, `int_o` and `crit_o` are cleared from the next edge, and strobed samples are ignored.
- R10: Queueing is enabled only by bit 4 of `cfg_byte`. The other bits of that byte have no effect.
- R11: Run counters saturate at `DEPTH`. A run of any length beyond `DEPTH` keeps the flag set, and after a clean sample a full new run of `DEPTH` samples is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | New sample strobe |
| below_low | input | 1 | Sample is below the low limit |
| above_high | input | 1 | Sample is above the high limit |
| above_crit | input | 1 | Sample is above the critical limit |
| cfg_byte | input | 8 | Configuration byte; bit 4 enables queueing |
| int_mode | input | 1 | 1 = latched interrupt mode, 0 = comparator mode |
| reg_rd | input | 1 | Pulse marking a register read on the bus |
| shutdown | input | 1 | Shutdown level |
| flag_low | output | 1 | Qualified low-limit flag |
| flag_high | output | 1 | Qualified high-limit flag |
| flag_crit | output | 1 | Qualified critical flag |
| int_o | output | 1 | Interrupt output |
| crit_o | output | 1 | Critical alarm output |

## Verification
The bench builds the block with its defaults: `DEPTH` = 4 and a 3-bit counter. At these values a run of three faulting samples is the last one that must stay silent, and a run of nine samples drives the counter well past its saturation point. Together with a clean sample inserted after a saturated run, this shows that a saturated counter restarts from zero rather than wrapping. The small depth keeps every threshold edge, restart and mode interaction within a few dozen cycles of directed stimulus.

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
  parameter int DEPTH = 4,
  parameter int QBIT  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_vld,
  input  logic       below_low,
  input  logic       above_high,
  input  logic       above_crit,
  input  logic [7:0] cfg_byte,
  input  logic       int_mode,
  input  logic       reg_rd,
  input  logic       shutdown,
  output logic       flag_low,
  output logic       flag_high,
  output logic       flag_crit,
  output logic       int_o,
  output logic       crit_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [2:0]    cond, q, q_nx;
  logic [CW-1:0] cnt [3];
  logic [CW-1:0] cnt_nx [3];
  logic          queue_en, take, int_evt, int_lat;

  assign cond     = {above_crit, above_high, below_low};
  assign queue_en = cfg_byte[QBIT];
  assign take     = smp_vld && !shutdown;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      if (!cond[i])          cnt_nx[i] = '0;
      else if (cnt[i] == CMAX) cnt_nx[i] = CMAX;
      else                   cnt_nx[i] = cnt[i] + 1'b1;
      q_nx[i] = cond[i] && (!queue_en || cnt_nx[i] == CMAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || shutdown) begin
      q <= '0;
      for (int i = 0; i < 3; i++) cnt[i] <= '0;
    end else if (smp_vld) begin
      q <= q_nx;
      for (int i = 0; i < 3; i++) cnt[i] <= cnt_nx[i];
    end
  end

  assign int_evt = take && int_mode && ((q_nx[0] && !q[0]) || (q_nx[1] && !q[1]));

  always_ff @(posedge clk) begin
    if (rst || shutdown || !int_mode) int_lat <= 1'b0;
    else if (int_evt)                 int_lat <= 1'b1;
    else if (reg_rd)                  int_lat <= 1'b0;
  end

  assign flag_low  = q[0];
  assign flag_high = q[1];
  assign flag_crit = q[2];
  assign crit_o    = q[2];
  assign int_o     = int_mode ? int_lat : (q[0] || q[1]);

  generate
    for (genvar g = 0; g < 3; g++) begin : g_chk
      p_sat_r11: assert property (@(posedge clk) disable iff (rst)
        cnt[g] <= CMAX);
      p_run_r2: assert property (@(posedge clk) disable iff (rst)
        take && queue_en && !q[g] |=> !q[g] || cnt[g] == CMAX);
      p_clean_r3: assert property (@(posedge clk) disable iff (rst)
        take && !cond[g] |=> !q[g] && cnt[g] == '0);
    end
  endgenerate

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !smp_vld && !shutdown |=> $stable(q));
  p_sd_r9: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> !int_o && !crit_o && q == 3'b000);
  p_rd_r7: assert property (@(posedge clk) disable iff (rst)
    int_mode && reg_rd && !int_evt |=> !int_o || !int_mode);
  p_evt_r7: assert property (@(posedge clk) disable iff (rst)
    int_evt |=> int_o || !int_mode || shutdown);
endmodule

// File: tb/test_fault_qualifier.sv
module test_fault_qualifier;
  logic clk = 1'b0, rst = 1'b1;
  logic smp_vld = 0, below_low = 0, above_high = 0, above_crit = 0;
  logic [7:0] cfg_byte = 8'h00;
  logic int_mode = 0, reg_rd = 0, shutdown = 0;
  logic flag_low, flag_high, flag_crit, int_o, crit_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  fault_qualifier i_fault_qualifier (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .below_low(below_low),
    .above_high(above_high), .above_crit(above_crit), .cfg_byte(cfg_byte),
    .int_mode(int_mode), .reg_rd(reg_rd), .shutdown(shutdown),
    .flag_low(flag_low), .flag_high(flag_high), .flag_crit(flag_crit),
    .int_o(int_o), .crit_o(crit_o));

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (low high crit int crit_o)", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {flag_low, flag_high, flag_crit, int_o, crit_o};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; smp_vld = 0; below_low = 0; above_high = 0; above_crit = 0;
    reg_rd = 0; shutdown = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic smp(input logic l, input logic h, input logic c, input logic rd = 1'b0);
    @(negedge clk);
    below_low = l; above_high = h; above_crit = c; smp_vld = 1; reg_rd = rd;
    @(negedge clk);
    smp_vld = 0; reg_rd = 0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", outs(), 5'b00000);
  endtask

  task automatic t_queue();
    do_reset(); cfg_byte = 8'h10; int_mode = 0;
    for (int k = 0; k < 3; k++) smp(0, 1, 0);
    chk("R2 three samples stay quiet", outs(), 5'b00000);
    smp(0, 1, 0);
    chk("R2 fourth sample qualifies, R6 int follows", outs(), 5'b01010);
    rd_pulse();
    chk("R6 read ignored in comparator mode", outs(), 5'b01010);
    smp(0, 0, 0);
    chk("R3 clean sample clears", outs(), 5'b00000);
  endtask

  task automatic t_restart();
    do_reset(); cfg_byte = 8'h10; int_mode = 0;
    for (int k = 0; k < 3; k++) smp(1, 0, 0);
    smp(0, 0, 0);
    for (int k = 0; k < 3; k++) smp(1, 0, 0);
    chk("R3 broken run restarts", outs(), 5'b00000);
    smp(1, 0, 0);
    chk("R3 new full run qualifies", outs(), 5'b10010);
  endtask

  task automatic t_sat();
    do_reset(); cfg_byte = 8'h10; int_mode = 0;
    for (int k = 0; k < 9; k++) smp(1, 0, 0);
    chk("R11 long run keeps flag", outs(), 5'b10010);
    smp(0, 0, 0);
    for (int k = 0; k < 3; k++) smp(1, 0, 0);
    chk("R11 saturated counter restarts from zero", outs(), 5'b00000);
  endtask

  task automatic t_nostrobe();
    do_reset(); cfg_byte = 8'h00; int_mode = 0;
    @(negedge clk); above_high = 1; below_low = 1; above_crit = 1;
    repeat (10) @(negedge clk);
    chk("R5 no strobe no change", outs(), 5'b00000);
    above_high = 0; below_low = 0; above_crit = 0;
  endtask

  task automatic t_noqueue();
    do_reset(); cfg_byte = 8'hEF; int_mode = 0;
    smp(0, 0, 1);
    chk("R4 R10 single sample qualifies with bit 4 clear", outs(), 5'b00101);
    rd_pulse();
    chk("R8 crit unaffected by read", outs(), 5'b00101);
    do_reset(); cfg_byte = 8'h10;
    smp(0, 0, 1);
    chk("R10 bit 4 alone enables queue", outs(), 5'b00000);
  endtask

  task automatic t_intmode();
    do_reset(); cfg_byte = 8'h00; int_mode = 1;
    smp(1, 0, 0);
    chk("R7 event sets int", outs(), 5'b10010);
    smp(1, 0, 0);
    chk("R7 int holds without read", outs(), 5'b10010);
    rd_pulse();
    chk("R7 read clears int, flag stays", outs(), 5'b10000);
    smp(0, 0, 0);
    smp(0, 1, 0, 1'b1);
    chk("R7 event wins over read", outs(), 5'b01010);
  endtask

  task automatic t_shutdown();
    do_reset(); cfg_byte = 8'h00; int_mode = 0;
    smp(0, 1, 1);
    chk("R9 precondition", outs(), 5'b01111);
    @(negedge clk); shutdown = 1;
    @(negedge clk);
    chk("R9 shutdown clears outputs", outs(), 5'b00000);
    smp(1, 1, 1);
    chk("R9 samples ignored in shutdown", outs(), 5'b00000);
    @(negedge clk); shutdown = 0;
    @(negedge clk);
    chk("R9 stays clear after release", outs(), 5'b00000);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_queue();
    t_restart();
    t_sat();
    t_nostrobe();
    t_noqueue();
    t_intmode();
    t_shutdown();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule